// File: doc/BRIEF.md
# Buffered Serial Transfer Controller

This block is the master-side sequencer of a clocked serial port. Software writes entries into a 16-deep buffer. Each entry holds an 8-bit data word and a 2-bit chip-select code. While transmit or receive is enabled, the controller takes entries from the buffer one at a time and shifts each out MSB first. In master mode it generates the serial clock itself and drives one of four active-low chip-select lines. In slave mode it follows an external clock and keeps every chip-select line inactive. A received word goes into a single receive holding register, and the host drains that register through a valid/ready read port.

Entries enter through a valid/ready write port with no waiting. `wr_ready` is simply the inverse of the full flag. A beat offered while `wr_ready` is low is not held: it is dropped, and the drop is reported on `ovf_irq`. On the receive side, `rx_valid` stays high until the host takes the word with `rx_ready`. This is the only back-pressure in the block. While `rx_valid` is high, a finished word is parked and not stored. Until the word is stored, the buffer entry it came from is not released and no further word is loaded.

Top module: `sertx_ctrl`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `count`=0, `busy`=0, `cs_n`=4'b1111, `rx_valid`=0, `sclk_out`=0, and both interrupt outputs are 0.
- R2: `wr_ready` equals the inverse of `full`. `count` equals accepted writes minus completed words. `full` is high exactly when `count` is 16, and `empty` exactly when `count` is 0.
- R3: A write beat offered while `full` is high is discarded and leaves `count` unchanged. `ovf_irq` pulses high for one cycle on the cycle after that beat.
- R4: No word is loaded and `sclk_out` stays low unless `tx_en` or `rx_en` is high and the buffer is non-empty. Entries written while both enables are low wait in the buffer.
- R5: In master mode (`clk_sel` not 3'b111), each word takes 16 clock cycles with 8 `sclk_out` pulses. It is sent MSB first on `sdo`, and `sdo` is valid at each rising edge of `sclk_out`. `sdo` stays 0 while `tx_en` is low.
- R6: With only `tx_en` high, every finished word pulses `done_irq` and decrements `count`, and `rx_valid` stays low.
- R7: With `rx_en` high and `rx_valid` low, a finished word is placed on `rx_data`. `rx_valid` rises in the same cycle that `done_irq` pulses.
- R8: If `rx_valid` is still high when a word finishes, storing it, `done_irq` and the `count` decrement are all deferred until the host reads. No further word is loaded meanwhile.
- R9: `busy` is set by a write accepted while either enable is high. It clears when a word completes and leaves the buffer empty.
- R10: In master mode, while `busy` is high, exactly one line `cs_n[k]` is low, where k is the 2-bit code of the entry in flight or next in line. All other lines are high, and all lines are high when `busy` is low.
- R11: In slave mode (`clk_sel` = 3'b111), `cs_n` is 4'b1111 and `sclk_out` is 0 at all times. Bits move on the rising edges of `sclk_in`.
- R12: A read is a cycle with `rx_valid` and `rx_ready` both high. It clears `rx_valid`. While `rx_valid` is high and not read, `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write beat offered |
| wr_data | input | 8 | Data word of the entry |
| wr_cs | input | 2 | Chip-select code of the entry |
| wr_ready | output | 1 | Buffer has room |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| clk_sel | input | 3 | Clock select; 3'b111 selects slave mode |
| sclk_in | input | 1 | External serial clock for slave mode |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip-select lines |
| rx_data | output | 8 | Receive holding register |
| rx_valid | output | 1 | Receive register holds an unread word |
| rx_ready | input | 1 | Host read strobe |
| busy | output | 1 | Transfer sequence in progress |
| full | output | 1 | Buffer holds 16 entries |
| empty | output | 1 | Buffer holds no entry |
| count | output | 5 | Remaining entries, including the word in flight |
| done_irq | output | 1 | One-cycle completion pulse |
| ovf_irq | output | 1 | One-cycle pulse for a discarded write |

## Verification
The assertions assume that `clk_sel` and the enables stay constant while a word is in flight. They also assume that `sclk_in` is slow enough, relative to `clk`, for every edge to be seen after two-stage sampling, and that `sdi` does not change near a sampling edge. The stimulus changes modes only right after a reset. It toggles `sclk_in` every four core cycles, and it either loops `sdo` back to `sdi` or holds `sdi` constant, so serial data settles long before it is sampled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_t;

  localparam logic [2:0] SLAVE_SEL = 3'b111;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 16,
  parameter int EW    = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [EW-1:0] wr_entry,
  output logic          wr_ready,
  output logic          wr_acc,
  output logic          ovf_pulse,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic [PW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, ld_ptr;

  assign count    = wr_ptr - ld_ptr;
  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign wr_ready = !full;
  assign wr_acc   = wr_valid && !full;
  assign head     = mem[ld_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr[AW-1:0]] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      ld_ptr    <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    ld_ptr <= ld_ptr + 1'b1;
      ovf_pulse <= wr_valid && full;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DW  = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          sclk_in,
  input  logic          start,
  input  logic [DW-1:0] load_word,
  input  logic          tx_en,
  input  logic          sdi,
  output logic          sclk_out,
  output logic          sdo,
  output logic          fin,
  output logic [DW-1:0] fin_word
);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  logic [DW-1:0] shreg;
  logic [BW-1:0] bitcnt;
  logic          active, phase;
  logic          s1, s2;
  logic          shift_evt;

  assign shift_evt = active && (master ? phase : (s1 && !s2));
  assign fin       = shift_evt && (bitcnt == LAST_BIT);
  assign fin_word  = {shreg[DW-2:0], sdi};
  assign sclk_out  = master && active && phase;
  assign sdo       = tx_en && active && shreg[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      active <= 1'b0;
      phase  <= 1'b0;
      s1     <= 1'b0;
      s2     <= 1'b0;
    end else begin
      s1 <= sclk_in;
      s2 <= s1;
      if (start) begin
        shreg  <= load_word;
        bitcnt <= '0;
        active <= 1'b1;
        phase  <= 1'b0;
      end else if (active) begin
        if (master) phase <= !phase;
        if (shift_evt) begin
          shreg  <= fin_word;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sertx_csdec.sv
module sertx_csdec #(
  parameter int CSW  = 2,
  localparam int NCS = 1 << CSW
) (
  input  logic [CSW-1:0] code,
  input  logic           enable,
  output logic [NCS-1:0] cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs_n[i] = !(enable && (code == CSW'(i)));
  end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CSW   = 2,
  localparam int EW   = DW + CSW,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int NCS  = 1 << CSW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [DW-1:0]  wr_data,
  input  logic [CSW-1:0] wr_cs,
  output logic           wr_ready,
  input  logic           tx_en,
  input  logic           rx_en,
  input  logic [2:0]     clk_sel,
  input  logic           sclk_in,
  output logic           sclk_out,
  output logic           sdo,
  input  logic           sdi,
  output logic [NCS-1:0] cs_n,
  output logic [DW-1:0]  rx_data,
  output logic           rx_valid,
  input  logic           rx_ready,
  output logic           busy,
  output logic           full,
  output logic           empty,
  output logic [PW-1:0]  count,
  output logic           done_irq,
  output logic           ovf_irq
);
  seq_state_t     state;
  logic           master, any_en;
  logic           wr_acc, start, fin, cmpl, store, rd;
  logic [EW-1:0]  head;
  logic [DW-1:0]  fin_word, pend, word_in;
  logic [CSW-1:0] cs_q, head_cs;

  assign master  = (clk_sel != SLAVE_SEL);
  assign any_en  = tx_en || rx_en;
  assign head_cs = head[EW-1:DW];

  sertx_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_entry({wr_cs, wr_data}),
    .wr_ready(wr_ready), .wr_acc(wr_acc), .ovf_pulse(ovf_irq),
    .pop(cmpl), .head(head), .count(count), .full(full), .empty(empty)
  );

  sertx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .master(master), .sclk_in(sclk_in),
    .start(start), .load_word(head[DW-1:0]), .tx_en(tx_en), .sdi(sdi),
    .sclk_out(sclk_out), .sdo(sdo), .fin(fin), .fin_word(fin_word)
  );

  sertx_csdec #(.CSW(CSW)) u_csdec (
    .code(cs_q), .enable(master && busy), .cs_n(cs_n)
  );

  assign rd     = rx_valid && rx_ready;
  assign start  = (state == SEQ_IDLE) && any_en && !empty;
  assign store  = ((state == SEQ_SHIFT) && fin && rx_en && !rx_valid) ||
                  ((state == SEQ_HOLD) && !rx_valid);
  assign cmpl   = ((state == SEQ_SHIFT) && fin && !(rx_en && rx_valid)) ||
                  ((state == SEQ_HOLD) && !rx_valid);
  assign word_in = (state == SEQ_HOLD) ? pend : fin_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      pend     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      done_irq <= 1'b0;
      busy     <= 1'b0;
      cs_q     <= '0;
    end else begin
      done_irq <= cmpl;
      unique case (state)
        SEQ_IDLE:  if (start) state <= SEQ_SHIFT;
        SEQ_SHIFT: if (fin) begin
          if (rx_en && rx_valid) begin
            pend  <= fin_word;
            state <= SEQ_HOLD;
          end else begin
            state <= SEQ_IDLE;
          end
        end
        SEQ_HOLD:  if (!rx_valid) state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase

      if (store) begin
        rx_data  <= word_in;
        rx_valid <= 1'b1;
      end else if (rd) begin
        rx_valid <= 1'b0;
      end

      if (wr_acc && any_en)                 busy <= 1'b1;
      else if (cmpl && count == PW'(1))     busy <= 1'b0;

      if (start)                 cs_q <= head_cs;
      else if (wr_acc && any_en) cs_q <= empty ? wr_cs : head_cs;
    end
  end
endmodule

// File: rtl/sertx_ctrl_chk.sv
module sertx_ctrl_chk #(
  parameter int PW  = 5,
  parameter int NCS = 4,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [2:0]     clk_sel,
  input logic           sclk_out,
  input logic [NCS-1:0] cs_n,
  input logic [DW-1:0]  rx_data,
  input logic           rx_valid,
  input logic           rx_ready,
  input logic           full,
  input logic           empty,
  input logic           done_irq,
  input logic           ovf_irq
);
  // R2
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> $past(wr_valid && !wr_ready));
  // R7
  rx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> done_irq);
  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R11
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b111) |-> (!sclk_out && (&cs_n)));
endmodule

bind sertx_ctrl sertx_ctrl_chk #(.PW(PW), .NCS(NCS), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .clk_sel(clk_sel), .sclk_out(sclk_out), .cs_n(cs_n), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .full(full), .empty(empty),
  .done_irq(done_irq), .ovf_irq(ovf_irq)
);

// File: tb/sertx_ctrl_tb_top.sv
`timescale 1ns/1ps
module sertx_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_cs = '0;
  logic       wr_ready;
  logic       tx_en = 1'b0, rx_en = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       sclk_in = 1'b0;
  logic       sclk_out, sdo, sdi;
  logic [3:0] cs_n;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       busy, full, empty, done_irq, ovf_irq;
  logic [4:0] count;
  logic       loop = 1'b0, sdi_drv = 1'b0;

  int n_chk = 0, n_bad = 0;
  int rises = 0, done_tot = 0, ovf_tot = 0, sdo_hi = 0, cs_bad = 0;
  logic [15:0] cap = '0;

  assign sdi = loop ? sdo : sdi_drv;

  always #4 clk = ~clk;

  sertx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_cs(wr_cs), .wr_ready(wr_ready), .tx_en(tx_en), .rx_en(rx_en),
    .clk_sel(clk_sel), .sclk_in(sclk_in), .sclk_out(sclk_out), .sdo(sdo),
    .sdi(sdi), .cs_n(cs_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .busy(busy), .full(full), .empty(empty),
    .count(count), .done_irq(done_irq), .ovf_irq(ovf_irq)
  );

  always @(posedge sclk_out) begin
    cap   = {cap[14:0], sdo};
    rises = rises + 1;
  end

  always @(negedge clk) begin
    if (done_irq) done_tot = done_tot + 1;
    if (ovf_irq)  ovf_tot  = ovf_tot + 1;
    if (sdo)      sdo_hi   = sdo_hi + 1;
    if (clk_sel == 3'b111 && cs_n != 4'hF) cs_bad = cs_bad + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] sel, input logic te, input logic re);
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rx_ready = 1'b0; sclk_in = 1'b0;
    clk_sel = sel; tx_en = te; rx_en = re;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic [1:0] c);
    wr_valid = 1'b1; wr_data = d; wr_cs = c;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 600 && done_tot < target; i++) @(negedge clk);
  endtask

  task automatic rd_pulse();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(3'd0, 1'b0, 1'b0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "count", count, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "cs_n", cs_n, 4'hF);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "irqs", {done_irq, ovf_irq, sclk_out}, 0);
  endtask

  task automatic t_no_start();
    int r0;
    do_reset(3'd0, 1'b0, 1'b0);
    r0 = rises;
    wr(8'h5A, 2'd0);
    wr(8'hC3, 2'd1);
    repeat (40) @(negedge clk);
    chk("R4", "sclk pulses while disabled", rises - r0, 0);
    chk("R2", "count after two writes", count, 2);
    chk("R9", "busy without enable", busy, 0);
  endtask

  task automatic t_tx_only();
    int r0, d0;
    do_reset(3'd2, 1'b1, 1'b0);
    r0 = rises; d0 = done_tot;
    wr(8'hA5, 2'd2);
    chk("R9", "busy after write", busy, 1);
    wr(8'h3C, 2'd1);
    while (rises < r0 + 1) @(negedge clk);
    chk("R10", "cs_n word 1", cs_n, 4'b1011);
    while (rises < r0 + 9) @(negedge clk);
    chk("R10", "cs_n word 2", cs_n, 4'b1101);
    wait_done(d0 + 2);
    @(negedge clk);
    chk("R5", "serial bits", cap, 16'hA53C);
    chk("R5", "clock pulses", rises - r0, 16);
    chk("R6", "done pulses", done_tot - d0, 2);
    chk("R6", "rx_valid", rx_valid, 0);
    chk("R6", "count", count, 0);
    chk("R9", "busy after drain", busy, 0);
    chk("R10", "cs_n idle", cs_n, 4'hF);
  endtask

  task automatic t_word_time();
    int t0;
    do_reset(3'd0, 1'b1, 1'b0);
    wr(8'h81, 2'd0);
    t0 = 0;
    while (!sclk_out && t0 < 50) begin @(negedge clk); t0++; end
    t0 = 0;
    while (!done_irq && t0 < 50) begin @(negedge clk); t0++; end
    // first high phase to completion pulse: 15 cycles of the 16-cycle word
    chk("R5", "cycles from first sclk high to done", t0, 15);
  endtask

  task automatic t_stall();
    int r0, d0;
    do_reset(3'd0, 1'b1, 1'b1);
    loop = 1'b1;
    r0 = rises; d0 = done_tot;
    wr(8'h11, 2'd0);
    wr(8'h22, 2'd0);
    wr(8'h33, 2'd0);
    wait_done(d0 + 1);
    chk("R7", "first rx word", rx_data, 8'h11);
    chk("R7", "rx_valid", rx_valid, 1);
    repeat (60) @(negedge clk);
    chk("R8", "done held", done_tot - d0, 1);
    chk("R8", "count held", count, 2);
    chk("R8", "no third load", rises - r0, 16);
    chk("R12", "rx_data held", rx_data, 8'h11);
    rd_pulse();
    wait_done(d0 + 2);
    chk("R8", "deferred word", rx_data, 8'h22);
    rd_pulse();
    wait_done(d0 + 3);
    chk("R7", "third word", rx_data, 8'h33);
    rd_pulse();
    chk("R12", "rx_valid after read", rx_valid, 0);
    chk("R9", "busy after last", busy, 0);
    chk("R2", "empty after drain", empty, 1);
    loop = 1'b0;
  endtask

  task automatic t_rx_only();
    int s0, d0;
    do_reset(3'd1, 1'b0, 1'b1);
    sdi_drv = 1'b1;
    d0 = done_tot;
    wr(8'hF0, 2'd3);
    s0 = sdo_hi;
    wait_done(d0 + 1);
    chk("R5", "sdo with tx off", sdo_hi - s0, 0);
    chk("R7", "rx word from sdi", rx_data, 8'hFF);
    sdi_drv = 1'b0;
    rd_pulse();
  endtask

  task automatic t_overflow();
    int o0;
    do_reset(3'd0, 1'b0, 1'b0);
    o0 = ovf_tot;
    for (int i = 0; i < 16; i++) wr(8'(i), 2'd0);
    chk("R2", "full", full, 1);
    chk("R2", "wr_ready", wr_ready, 0);
    chk("R2", "count", count, 16);
    chk("R3", "no ovf yet", ovf_tot - o0, 0);
    wr(8'hEE, 2'd1);
    @(negedge clk);
    chk("R3", "ovf pulses", ovf_tot - o0, 1);
    chk("R3", "count unchanged", count, 16);
  endtask

  task automatic t_slave();
    int r0, d0, c0;
    do_reset(3'b111, 1'b1, 1'b1);
    loop = 1'b1;
    r0 = rises; d0 = done_tot; c0 = cs_bad;
    wr(8'h96, 2'd3);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b1; repeat (4) @(negedge clk);
      sclk_in = 1'b0; repeat (4) @(negedge clk);
    end
    wait_done(d0 + 1);
    chk("R11", "word via sclk_in", rx_data, 8'h96);
    chk("R11", "sclk_out quiet", rises - r0, 0);
    chk("R11", "cs_n inactive", cs_bad - c0, 0);
    loop = 1'b0;
    rd_pulse();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_start();
    t_tx_only();
    t_word_time();
    t_stall();
    t_rx_only();
    t_overflow();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule